// File: doc/BRIEF.md
# Queue-Port Host Messaging Unit

This block connects a host register bus to a controller core. Work moves through two address-mapped queue ports. Reading the inbound port takes a free local request slot from a pool. Writing the inbound port posts a request word to the core. The core pushes finished requests into a completion queue, and the host drains that queue by reading the outbound port. Writing the outbound port hands a local slot back to the pool. A posted word with bit 31 set names a request held in host memory: its low 31 bits are the bus address shifted right by five, so such requests are 32-byte aligned. A word with bit 31 clear is an offset into the controller's local window.

Two other paths need no queue. Inbound and outbound message registers carry non-queued commands: the core acknowledges a command by echoing its value into outbound message 0. An inbound doorbell raises maskable interrupt bits toward the core. On the host side, an outbound status and mask pair drives a level interrupt.

The host interface is single-cycle. The read data is combinational from the address while `h_sel` is high and `h_wr` is low, and any pop takes effect on that clock edge. All three FIFOs are `DEPTH` entries deep, and `DEPTH` must be a power of two.

Top module: `qport_msg_unit`

## Requirements
- R1: The map is fixed:
  - Inbound messages 0 and 1 sit at 0x10 and 0x14, and are readable and writable by the host.
  - Outbound messages 0 and 1 sit at 0x18 and 0x1C, and are read-only to the host.
  - The doorbell is at 0x20. The inbound status is at 0x24 (read-only). The inbound mask is at 0x28.
  - The outbound status is at 0x30 and the outbound mask at 0x34.
  - The queue ports are at 0x40 (inbound) and 0x44 (outbound).
  - Unmapped addresses read 0.
  - After reset, all status bits are 0, the inbound mask is 0xFFFFFFFF and the outbound mask is 0x7.
- R2: A host read of 0x40 returns the oldest free slot and removes it. If the pool is empty, the read returns 0xFFFFFFFF and removes nothing.
- R3: A host write of 0x40 appends the word to the request FIFO. `c_req_valid` and `c_req_data` show the oldest entry. `c_req_pop` removes it, and words reach the core in the order they were posted.
- R4: A host write of 0x44 with bit 31 clear returns that offset to the free pool. With bit 31 set, the write is ignored. A core free push and a host free in the same cycle are both kept, with the core's entry first.
- R5: A core completion push is queued. A host read of 0x44 returns the completions in push order. An empty queue reads 0xFFFFFFFF and nothing is removed.
- R6: Outbound status has three bits:
  - Bit 0 reads 1 exactly while the completion FIFO is non-empty.
  - Bit 2 is a sticky overflow flag. It is set when a push into any full FIFO is dropped, and cleared by writing 1 to bit 2 of 0x30.
  - A dropped push leaves the stored entries unchanged.
- R7: A host write of 0x10 updates `c_imsg0` and pulses `c_cmd_valid` for the single cycle after the write. A core write of outbound message 0 sets outbound status bit 1, which is cleared by writing 1 to that bit of 0x30.
- R8: A host write of 0x20 ORs the written word into the inbound status. `c_db_clear` clears bits, and a set in the same cycle wins. `c_db_irq` is the OR of the status bits whose mask bit is 0.
- R9: `h_irq` is the OR of the outbound status bits whose mask bit is 0. A mask bit of 1 disables that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | 1 for write, 0 for read |
| h_addr | input | 8 | Register byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| h_irq | output | 1 | Level interrupt to the host |
| c_req_valid | output | 1 | Request FIFO not empty |
| c_req_data | output | 32 | Oldest posted request word |
| c_req_pop | input | 1 | Core removes the oldest request |
| c_cpl_push | input | 1 | Core pushes a completion |
| c_cpl_data | input | 32 | Completion word (offset, tagged host word or context) |
| c_free_push | input | 1 | Core returns a local slot to the pool |
| c_free_data | input | 32 | Offset of the returned slot |
| c_imsg0 | output | 32 | Inbound message 0 |
| c_imsg1 | output | 32 | Inbound message 1 |
| c_cmd_valid | output | 1 | One-cycle pulse after a host write of inbound message 0 |
| c_omsg_we | input | 2 | Core write enables for outbound messages 1:0 |
| c_omsg_data | input | 32 | Core outbound message data |
| c_db_status | output | 32 | Inbound doorbell status |
| c_db_clear | input | 32 | Per-bit clear of the inbound status |
| c_db_irq | output | 1 | Unmasked doorbell interrupt to the core |

## Verification
The bench concentrates on the corner cases of the queue ports:
- An empty pool or an empty completion queue is read. A design that popped anyway would corrupt its pointers, and the next slot returned would be stale.
- The request FIFO is filled one word past its depth. A design that wrapped would overwrite the oldest request, and the core would drain a wrong first word.
- The host frees a host-memory word with bit 31 set. A design that queued it would later hand out a bogus slot.
- The core and the host free a slot in the same cycle. A single-lane pool would lose one of the two.

Two further cases cover the control bits. The write-1-to-clear flags and the one-cycle command pulse are checked both before and after they are cleared. A set-versus-clear race on the doorbell is checked, where a design with the wrong priority would drop a freshly rung bit.

// File: rtl/qport_msg_unit.sv
module qport_msg_unit #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_sel,
  input  logic        h_wr,
  input  logic [7:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  output logic        c_req_valid,
  output logic [31:0] c_req_data,
  input  logic        c_req_pop,
  input  logic        c_cpl_push,
  input  logic [31:0] c_cpl_data,
  input  logic        c_free_push,
  input  logic [31:0] c_free_data,
  output logic [31:0] c_imsg0,
  output logic [31:0] c_imsg1,
  output logic        c_cmd_valid,
  input  logic [1:0]  c_omsg_we,
  input  logic [31:0] c_omsg_data,
  output logic [31:0] c_db_status,
  input  logic [31:0] c_db_clear,
  output logic        c_db_irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] A_IM0 = 8'h10, A_IM1 = 8'h14, A_OM0 = 8'h18, A_OM1 = 8'h1C;
  localparam logic [7:0] A_DB = 8'h20, A_IST = 8'h24, A_IMSK = 8'h28;
  localparam logic [7:0] A_OST = 8'h30, A_OMSK = 8'h34, A_INQ = 8'h40, A_OUTQ = 8'h44;
  localparam int F_REQ = 0, F_CPL = 1, F_FREE = 2;

  logic        h_rd, h_we;
  logic [31:0] imsg0, imsg1, omsg0, omsg1, istat, imask;
  logic [2:0]  omask;
  logic        mdone, ovf, cmd_q;
  logic [2:0]  push_a, push_b, pop, drop, nempty;
  logic [31:0] din_a [3];
  logic [31:0] din_b [3];
  logic [31:0] head [3];
  logic [CW-1:0] cnt [3];
  logic [2:0]  ostat;

  assign h_rd = h_sel && !h_wr;
  assign h_we = h_sel && h_wr;

  // queue lane wiring: 0 = posted requests, 1 = completions, 2 = free slots
  assign push_a[F_REQ]  = h_we && h_addr == A_INQ;
  assign din_a[F_REQ]   = h_wdata;
  assign push_b[F_REQ]  = 1'b0;
  assign din_b[F_REQ]   = '0;
  assign pop[F_REQ]     = c_req_pop;

  assign push_a[F_CPL]  = c_cpl_push;
  assign din_a[F_CPL]   = c_cpl_data;
  assign push_b[F_CPL]  = 1'b0;
  assign din_b[F_CPL]   = '0;
  assign pop[F_CPL]     = h_rd && h_addr == A_OUTQ;

  assign push_a[F_FREE] = c_free_push;
  assign din_a[F_FREE]  = c_free_data;
  assign push_b[F_FREE] = h_we && h_addr == A_OUTQ && !h_wdata[31];
  assign din_b[F_FREE]  = h_wdata;
  assign pop[F_FREE]    = h_rd && h_addr == A_INQ;

  for (genvar g = 0; g < 3; g++) begin : g_fifo
    logic [31:0]   mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] n;
    logic [CW:0]   space;
    logic          do_pop, acc_a, acc_b;

    assign do_pop = pop[g] && n != '0;
    assign space  = (CW+1)'(DEPTH) - {1'b0, n} + (CW+1)'(do_pop);
    assign acc_a  = push_a[g] && space != '0;
    assign acc_b  = push_b[g] && space > (CW+1)'(acc_a);

    always_ff @(posedge clk) begin
      if (acc_a) mem[wp] <= din_a[g];
      if (acc_b) mem[wp + PW'(acc_a)] <= din_b[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
        n  <= '0;
      end else begin
        wp <= wp + PW'(acc_a) + PW'(acc_b);
        if (do_pop) rp <= rp + PW'(1);
        n <= n + CW'(acc_a) + CW'(acc_b) - CW'(do_pop);
      end
    end

    assign head[g]   = mem[rp];
    assign cnt[g]    = n;
    assign nempty[g] = n != '0;
    assign drop[g]   = (push_a[g] && !acc_a) || (push_b[g] && !acc_b);

    p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      n <= CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imsg0 <= '0;
      imsg1 <= '0;
      omsg0 <= '0;
      omsg1 <= '0;
      istat <= '0;
      imask <= '1;
      omask <= '1;
      mdone <= 1'b0;
      ovf   <= 1'b0;
      cmd_q <= 1'b0;
    end else begin
      cmd_q <= h_we && h_addr == A_IM0;
      if (h_we && h_addr == A_IM0)  imsg0 <= h_wdata;
      if (h_we && h_addr == A_IM1)  imsg1 <= h_wdata;
      if (h_we && h_addr == A_IMSK) imask <= h_wdata;
      if (h_we && h_addr == A_OMSK) omask <= h_wdata[2:0];
      if (c_omsg_we[0]) omsg0 <= c_omsg_data;
      if (c_omsg_we[1]) omsg1 <= c_omsg_data;
      istat <= (istat & ~c_db_clear) | ((h_we && h_addr == A_DB) ? h_wdata : 32'h0);
      mdone <= c_omsg_we[0] || (mdone && !(h_we && h_addr == A_OST && h_wdata[1]));
      ovf   <= (|drop) || (ovf && !(h_we && h_addr == A_OST && h_wdata[2]));
    end
  end

  assign ostat = {ovf, mdone, nempty[F_CPL]};

  always_comb begin
    h_rdata = '0;
    if (h_rd) begin
      case (h_addr)
        A_IM0:  h_rdata = imsg0;
        A_IM1:  h_rdata = imsg1;
        A_OM0:  h_rdata = omsg0;
        A_OM1:  h_rdata = omsg1;
        A_DB:   h_rdata = istat;
        A_IST:  h_rdata = istat;
        A_IMSK: h_rdata = imask;
        A_OST:  h_rdata = {29'h0, ostat};
        A_OMSK: h_rdata = {29'h0, omask};
        A_INQ:  h_rdata = nempty[F_FREE] ? head[F_FREE] : 32'hFFFF_FFFF;
        A_OUTQ: h_rdata = nempty[F_CPL] ? head[F_CPL] : 32'hFFFF_FFFF;
        default: h_rdata = '0;
      endcase
    end
  end

  assign h_irq       = |(ostat & ~omask);
  assign c_db_irq    = |(istat & ~imask);
  assign c_db_status = istat;
  assign c_req_valid = nempty[F_REQ];
  assign c_req_data  = head[F_REQ];
  assign c_imsg0     = imsg0;
  assign c_imsg1     = imsg1;
  assign c_cmd_valid = cmd_q;

  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_IM0) |=> (c_cmd_valid && c_imsg0 == $past(h_wdata)));

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (omask == 3'b111) |-> !h_irq);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(h_we && h_addr == A_OST && h_wdata[2])) |=> ovf);

  p_empty_nopop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == A_INQ && cnt[F_FREE] == '0 && !c_free_push) |=> cnt[F_FREE] == '0);

  p_db_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_DB) |=> ((c_db_status & $past(h_wdata)) == $past(h_wdata)));
endmodule

// File: tb/test_qport_msg_unit.sv
`timescale 1ns/1ps
module test_qport_msg_unit;
  localparam int DEPTH = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 0, h_wr = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_wdata = 0;
  logic [31:0] h_rdata;
  logic        h_irq, c_req_valid, c_cmd_valid, c_db_irq;
  logic [31:0] c_req_data, c_imsg0, c_imsg1, c_db_status;
  logic        c_req_pop = 0, c_cpl_push = 0, c_free_push = 0;
  logic [31:0] c_cpl_data = 0, c_free_data = 0, c_omsg_data = 0, c_db_clear = 0;
  logic [1:0]  c_omsg_we = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qport_msg_unit #(.DEPTH(DEPTH)) i_qport_msg_unit (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .c_req_valid(c_req_valid), .c_req_data(c_req_data), .c_req_pop(c_req_pop),
    .c_cpl_push(c_cpl_push), .c_cpl_data(c_cpl_data),
    .c_free_push(c_free_push), .c_free_data(c_free_data),
    .c_imsg0(c_imsg0), .c_imsg1(c_imsg1), .c_cmd_valid(c_cmd_valid),
    .c_omsg_we(c_omsg_we), .c_omsg_data(c_omsg_data),
    .c_db_status(c_db_status), .c_db_clear(c_db_clear), .c_db_irq(c_db_irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(posedge clk); #1;
    h_sel = 0; h_wr = 0;
  endtask

  task automatic hrd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    h_sel = 1; h_wr = 0; h_addr = a;
    #1 chk(h_rdata === exp, tag, h_rdata, exp);
    @(posedge clk); #1;
    h_sel = 0;
  endtask

  task automatic cpop(input logic [31:0] exp, input string tag);
    @(negedge clk);
    chk(c_req_valid === 1'b1 && c_req_data === exp, tag, c_req_data, exp);
    c_req_pop = 1;
    @(posedge clk); #1;
    c_req_pop = 0;
  endtask

  task automatic cpl(input logic [31:0] d);
    @(negedge clk);
    c_cpl_push = 1; c_cpl_data = d;
    @(posedge clk); #1;
    c_cpl_push = 0;
  endtask

  // {write, addr, data, expected read}
  localparam int NV = 16;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h34, 32'h0, 32'h0000_0007},   // R1 reset outbound mask
    {1'b0, 8'h28, 32'h0, 32'hFFFF_FFFF},   // R1 reset inbound mask
    {1'b0, 8'h30, 32'h0, 32'h0},           // R1 reset outbound status
    {1'b0, 8'h3C, 32'h0, 32'h0},           // R1 unmapped
    {1'b1, 8'h10, 32'hAB, 32'h0},          // R1 imsg0
    {1'b0, 8'h10, 32'h0, 32'hAB},
    {1'b1, 8'h14, 32'h12, 32'h0},          // R1 imsg1
    {1'b0, 8'h14, 32'h0, 32'h12},
    {1'b1, 8'h20, 32'h5, 32'h0},           // R8 doorbell set
    {1'b0, 8'h24, 32'h0, 32'h5},
    {1'b0, 8'h40, 32'h0, 32'hFFFF_FFFF},   // R2 empty pool
    {1'b0, 8'h44, 32'h0, 32'hFFFF_FFFF},   // R5 empty completions
    {1'b1, 8'h44, 32'h100, 32'h0},         // R4 free a local slot
    {1'b0, 8'h40, 32'h0, 32'h100},         // R2 pop it
    {1'b1, 8'h44, 32'h8000_0010, 32'h0},   // R4 host word ignored
    {1'b0, 8'h40, 32'h0, 32'hFFFF_FFFF}    // R4 nothing queued
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(h_irq === 1'b0 && c_db_irq === 1'b0 && c_req_valid === 1'b0, "R1 reset outputs",
        {29'h0, h_irq, c_db_irq, c_req_valid}, 32'h0);
    rst_n = 1;

    foreach (VEC[i]) begin
      if (VEC[i][72]) hwr(VEC[i][71:64], VEC[i][63:32]);
      else hrd(VEC[i][71:64], VEC[i][31:0], $sformatf("R1/R2/R4/R5/R8 table vector %0d", i));
    end

    // R8 doorbell interrupt, clear, and set-over-clear
    chk(c_db_irq === 1'b0, "R8 masked doorbell", {31'h0, c_db_irq}, 32'h0);
    hwr(8'h28, 32'hFFFF_FFFE);
    chk(c_db_irq === 1'b1, "R8 unmasked doorbell", {31'h0, c_db_irq}, 32'h1);
    @(negedge clk); c_db_clear = 32'h1; @(posedge clk); #1; c_db_clear = 0;
    chk(c_db_status === 32'h4 && c_db_irq === 1'b0, "R8 core clear", c_db_status, 32'h4);
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_addr = 8'h20; h_wdata = 32'h1; c_db_clear = 32'h1;
    @(posedge clk); #1; h_sel = 0; h_wr = 0; c_db_clear = 0;
    chk(c_db_status === 32'h5, "R8 set wins over clear", c_db_status, 32'h5);

    // R7 message command and acknowledge
    hwr(8'h10, 32'h77);
    chk(c_cmd_valid === 1'b1 && c_imsg0 === 32'h77, "R7 command pulse", c_imsg0, 32'h77);
    @(posedge clk); #1;
    chk(c_cmd_valid === 1'b0, "R7 pulse one cycle", {31'h0, c_cmd_valid}, 32'h0);
    @(negedge clk); c_omsg_we = 2'b01; c_omsg_data = 32'h77;
    @(posedge clk); #1; c_omsg_we = 0;
    hrd(8'h18, 32'h77, "R7 outbound message 0");
    hrd(8'h30, 32'h2, "R7 message done bit");
    chk(h_irq === 1'b0, "R9 masked host irq", {31'h0, h_irq}, 32'h0);
    hwr(8'h34, 32'h0);
    chk(h_irq === 1'b1, "R9 unmasked host irq", {31'h0, h_irq}, 32'h1);
    hwr(8'h30, 32'h2);
    hrd(8'h30, 32'h0, "R7 done cleared");
    chk(h_irq === 1'b0, "R9 irq drops", {31'h0, h_irq}, 32'h0);

    // R5 completions, order and R6 bit0
    cpl(32'h0000_0200); cpl(32'h8000_0123); cpl(32'hC0FF_EE00);
    chk(h_irq === 1'b1, "R6 R9 completion raises irq", {31'h0, h_irq}, 32'h1);
    hrd(8'h30, 32'h1, "R6 not-empty bit");
    hrd(8'h44, 32'h0000_0200, "R5 completion 1");
    hrd(8'h44, 32'h8000_0123, "R5 completion 2");
    hrd(8'h44, 32'hC0FF_EE00, "R5 context completion 3");
    hrd(8'h44, 32'hFFFF_FFFF, "R5 drained");
    hrd(8'h30, 32'h0, "R6 not-empty clears");

    // R3 posts and R6 overflow
    for (int k = 0; k <= DEPTH; k++) hwr(8'h40, 32'h1000 + k);
    hrd(8'h30, 32'h4, "R6 overflow sticky");
    hrd(8'h30, 32'h4, "R6 overflow holds");
    hwr(8'h30, 32'h4);
    hrd(8'h30, 32'h0, "R6 overflow cleared");
    for (int k = 0; k < DEPTH; k++) cpop(32'h1000 + k, "R3 R6 post order");
    @(negedge clk);
    chk(c_req_valid === 1'b0, "R6 dropped post absent", {31'h0, c_req_valid}, 32'h0);

    // R4 simultaneous frees, core first
    @(negedge clk);
    c_free_push = 1; c_free_data = 32'hA0;
    h_sel = 1; h_wr = 1; h_addr = 8'h44; h_wdata = 32'hB0;
    @(posedge clk); #1;
    c_free_push = 0; h_sel = 0; h_wr = 0;
    hrd(8'h40, 32'hA0, "R4 core free first");
    hrd(8'h40, 32'hB0, "R4 host free second");
    hrd(8'h40, 32'hFFFF_FFFF, "R2 pool empty again");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule